// File: doc/BRIEF.md
# Nested Interrupt Pending/Active Controller

This block arbitrates a parameterized set of level-sensitive external interrupt lines for a processor core. Each line has an enable bit, a pending bit, an active bit and a programmable priority. The controller offers the core the most urgent interrupt that is pending and enabled. It makes that offer only when the interrupt outranks every handler that is already running, so handlers nest by priority.

The pending bit follows the level-sensitive rules. A rising input edge always pends the interrupt. A line that is still high when its handler completes is pended again. Software cannot clear the pending bit of a line that is held high while the interrupt is idle. A word-addressed register port gives software set and clear access to enables and pending bits, per-line priority fields, and a status word. The status word holds the winning vector number and a summary flag that counts disabled pending interrupts too.

The core takes the offered interrupt with `ack` and ends a handler with `cmpl` plus the handler's vector number. External line k uses vector number k+16.

Top module: `nvic_ctrl`

## Requirements
- R1: A low-to-high transition on `irq_lvl[k]` sets pending bit k in the next cycle, whether or not interrupt k is active.
- R2: When a completion clears active bit k while `irq_lvl[k]` is high, pending bit k is set in that same update.
- R3: A 1 written to clear-pending bit k is ignored while `irq_lvl[k]` is high and active bit k is 0. In every other case it clears pending bit k.
- R4: `ack` while `irq_req` is high clears the offered interrupt's pending bit and sets its active bit in the same update, even when its line is high.
- R5: Status word bits [20:12] hold the vector number (k+16) of the pending and enabled interrupt with the numerically lowest priority, with ties going to the lower k. The field is 0 when no such interrupt exists, and it is 9 bits wide so vectors above 255 are reported.
- R6: Status word bit 22 is 1 whenever any interrupt is pending, enabled or not. All other status bits read 0.
- R7: Each priority field is 8 bits, four per word, with line k in byte k%4 of priority word k/4. Only the top PRIO_BITS bits (3 to 8) are stored. The lower bits read 0 and ignore writes.
- R8: `irq_req` is high, with `irq_vec` equal to the status vector, only when the winning interrupt's priority is numerically lower than that of every active interrupt.
- R9: Writing 1 to set-pending sets the bit unconditionally. Writing 0 to any set or clear bit has no effect. All state resets to 0.
- R10: A word address is {region[2:0], index[6:0]}. The regions are: 0 set-enable, 1 clear-enable, 2 set-pending, 3 clear-pending, 4 active (read-only), 5 priority, 6 status. Bit b of index w in regions 0 to 4 is line 32w+b. Regions 0/1 read the enables and regions 2/3 read the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_lvl | input | NUM_IRQ | Level-sensitive interrupt lines |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Register write data |
| we | input | 1 | Register write strobe |
| rdata | output | 32 | Register read data (combinational) |
| irq_req | output | 1 | An interrupt is offered to the core |
| irq_vec | output | 9 | Vector number of the offered interrupt |
| ack | input | 1 | Core takes the offered interrupt |
| cmpl | input | 1 | Core completes a handler |
| cmpl_vec | input | 9 | Vector number of the completing handler |

## Verification
The hardest state to reach is a completion that lands while the line is still held high. Reaching it needs an edge, an acknowledge and a completion in order, with the line never dropping in between. The bench keeps one line high from its first edge through acknowledge and completion. It tries a clear-pending write while the line is high and idle, and again after acknowledge. A second interrupt is raised under the running handler to test nesting against priority. Vectors above 255 need a wide configuration, so the bench builds the block with 256 lines.

// File: rtl/nvic_pkg.sv
package nvic_pkg;
  localparam int VEC_W    = 9;
  localparam int VEC_BASE = 16;

  typedef enum logic [2:0] {
    RG_EN_SET  = 3'd0,
    RG_EN_CLR  = 3'd1,
    RG_PD_SET  = 3'd2,
    RG_PD_CLR  = 3'd3,
    RG_ACTIVE  = 3'd4,
    RG_PRIO    = 3'd5,
    RG_STATUS  = 3'd6,
    RG_NONE    = 3'd7
  } region_e;

  // vector number reported for external line idx
  function automatic logic [VEC_W-1:0] vec_of(int idx);
    return VEC_W'(idx + VEC_BASE);
  endfunction

  // expand a stored priority of 'bits' width to its 8-bit register view
  function automatic logic [7:0] prio_view(logic [7:0] stored, int bits);
    logic [7:0] v;
    v = stored << (8 - bits);
    return v;
  endfunction
endpackage

// File: rtl/nvic_line.sv
module nvic_line #(
  parameter int PRIO_BITS = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lvl,
  input  logic                 en_set,
  input  logic                 en_clr,
  input  logic                 pd_set,
  input  logic                 pd_clr,
  input  logic                 prio_we,
  input  logic [PRIO_BITS-1:0] prio_wd,
  input  logic                 ack_hit,
  input  logic                 cmpl_hit,
  output logic                 enable,
  output logic                 pending,
  output logic                 active,
  output logic [PRIO_BITS-1:0] prio,
  output logic                 rise,
  output logic                 repend,
  output logic                 clr_block
);
  logic lvl_q;
  logic set_p, clr_p;

  assign rise      = lvl & ~lvl_q;
  assign clr_block = pd_clr & lvl & ~active;
  assign repend    = cmpl_hit & active & lvl;
  assign set_p     = rise | pd_set | repend;
  assign clr_p     = ack_hit | (pd_clr & ~clr_block);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= 1'b0;
      enable  <= 1'b0;
      pending <= 1'b0;
      active  <= 1'b0;
      prio    <= '0;
    end else begin
      lvl_q <= lvl;
      if (en_set)      enable <= 1'b1;
      else if (en_clr) enable <= 1'b0;
      if (set_p)       pending <= 1'b1;
      else if (clr_p)  pending <= 1'b0;
      active <= (active & ~cmpl_hit) | ack_hit;
      if (prio_we)     prio <= prio_wd;
    end
  end
endmodule

// File: rtl/nvic_arb.sv
module nvic_arb #(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 3,
  localparam int IDX_W    = $clog2(NUM_IRQ > 1 ? NUM_IRQ : 2)
) (
  input  logic [NUM_IRQ-1:0]           cand,
  input  logic [NUM_IRQ-1:0]           act,
  input  logic [NUM_IRQ*PRIO_BITS-1:0] prio,
  output logic                         found,
  output logic [IDX_W-1:0]             best_idx,
  output logic                         offer
);
  logic [PRIO_BITS-1:0] best_prio, act_min;
  logic                 any_act;

  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    any_act   = 1'b0;
    act_min   = '0;
    for (int k = 0; k < NUM_IRQ; k++) begin
      // strict compare keeps the lower index on a tie
      if (cand[k] && (!found || prio[k*PRIO_BITS +: PRIO_BITS] < best_prio)) begin
        found     = 1'b1;
        best_idx  = IDX_W'(k);
        best_prio = prio[k*PRIO_BITS +: PRIO_BITS];
      end
      if (act[k] && (!any_act || prio[k*PRIO_BITS +: PRIO_BITS] < act_min)) begin
        any_act = 1'b1;
        act_min = prio[k*PRIO_BITS +: PRIO_BITS];
      end
    end
    offer = found && (!any_act || best_prio < act_min);
  end
endmodule

// File: rtl/nvic_regif.sv
module nvic_regif
  import nvic_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 10
) (
  input  logic [ADDR_W-1:0]            addr,
  input  logic [31:0]                  wdata,
  input  logic                         we,
  input  logic [NUM_IRQ-1:0]           enable,
  input  logic [NUM_IRQ-1:0]           pending,
  input  logic [NUM_IRQ-1:0]           active,
  input  logic [NUM_IRQ*PRIO_BITS-1:0] prio,
  input  logic [VEC_W-1:0]             status_vec,
  input  logic                         summary,
  output logic [NUM_IRQ-1:0]           en_set_v,
  output logic [NUM_IRQ-1:0]           en_clr_v,
  output logic [NUM_IRQ-1:0]           pd_set_v,
  output logic [NUM_IRQ-1:0]           pd_clr_v,
  output logic [NUM_IRQ-1:0]           prio_we_v,
  output logic [NUM_IRQ*PRIO_BITS-1:0] prio_wd_v,
  output logic [31:0]                  rdata
);
  localparam int IDX_W = ADDR_W - 3;
  localparam int NW    = (NUM_IRQ + 31) / 32;
  localparam int NPW   = (NUM_IRQ + 3) / 4;

  region_e          region;
  logic [IDX_W-1:0] idx;
  logic [NW*32-1:0]  en_pad, pd_pad, ac_pad;
  logic [NPW*32-1:0] pr_pad;

  assign region = region_e'(addr[ADDR_W-1 -: 3]);
  assign idx    = addr[IDX_W-1:0];

  always_comb begin
    for (int k = 0; k < NUM_IRQ; k++) begin
      en_set_v[k]  = we && region == RG_EN_SET && int'(idx) == k / 32 && wdata[k % 32];
      en_clr_v[k]  = we && region == RG_EN_CLR && int'(idx) == k / 32 && wdata[k % 32];
      pd_set_v[k]  = we && region == RG_PD_SET && int'(idx) == k / 32 && wdata[k % 32];
      pd_clr_v[k]  = we && region == RG_PD_CLR && int'(idx) == k / 32 && wdata[k % 32];
      prio_we_v[k] = we && region == RG_PRIO && int'(idx) == k / 4;
      prio_wd_v[k*PRIO_BITS +: PRIO_BITS] = wdata[(k % 4) * 8 + 7 -: PRIO_BITS];
    end
  end

  always_comb begin
    en_pad = '0;
    pd_pad = '0;
    ac_pad = '0;
    pr_pad = '0;
    en_pad[NUM_IRQ-1:0] = enable;
    pd_pad[NUM_IRQ-1:0] = pending;
    ac_pad[NUM_IRQ-1:0] = active;
    for (int k = 0; k < NUM_IRQ; k++)
      pr_pad[k*8 +: 8] = prio_view(8'(prio[k*PRIO_BITS +: PRIO_BITS]), PRIO_BITS);
  end

  always_comb begin
    rdata = '0;
    unique case (region)
      RG_EN_SET, RG_EN_CLR: if (int'(idx) < NW) rdata = en_pad[int'(idx)*32 +: 32];
      RG_PD_SET, RG_PD_CLR: if (int'(idx) < NW) rdata = pd_pad[int'(idx)*32 +: 32];
      RG_ACTIVE:            if (int'(idx) < NW) rdata = ac_pad[int'(idx)*32 +: 32];
      RG_PRIO:              if (int'(idx) < NPW) rdata = pr_pad[int'(idx)*32 +: 32];
      RG_STATUS:            rdata = {9'd0, summary, 1'b0, status_vec, 12'd0};
      default:              rdata = '0;
    endcase
  end
endmodule

// File: rtl/nvic_ctrl.sv
module nvic_ctrl
  import nvic_pkg::*;
#(
  parameter int NUM_IRQ   = 32,
  parameter int PRIO_BITS = 3,
  parameter int ADDR_W    = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_lvl,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [31:0]        wdata,
  input  logic               we,
  output logic [31:0]        rdata,
  output logic               irq_req,
  output logic [8:0]         irq_vec,
  input  logic               ack,
  input  logic               cmpl,
  input  logic [8:0]         cmpl_vec
);
  localparam int IDX_W = $clog2(NUM_IRQ > 1 ? NUM_IRQ : 2);

  logic [NUM_IRQ-1:0] enable, pending, active;
  logic [NUM_IRQ-1:0] rise_v, repend_v, clr_block_v;
  logic [NUM_IRQ-1:0] ack_hit_v, cmpl_hit_v;
  logic [NUM_IRQ-1:0] en_set_v, en_clr_v, pd_set_v, pd_clr_v, prio_we_v;
  logic [NUM_IRQ*PRIO_BITS-1:0] prio_flat, prio_wd_v;
  logic               found, offer, summary;
  logic [IDX_W-1:0]   best_idx;
  logic [VEC_W-1:0]   status_vec;

  nvic_regif #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS), .ADDR_W(ADDR_W)) u_regif (
    .addr(addr), .wdata(wdata), .we(we),
    .enable(enable), .pending(pending), .active(active), .prio(prio_flat),
    .status_vec(status_vec), .summary(summary),
    .en_set_v(en_set_v), .en_clr_v(en_clr_v), .pd_set_v(pd_set_v), .pd_clr_v(pd_clr_v),
    .prio_we_v(prio_we_v), .prio_wd_v(prio_wd_v), .rdata(rdata)
  );

  nvic_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_arb (
    .cand(pending & enable), .act(active), .prio(prio_flat),
    .found(found), .best_idx(best_idx), .offer(offer)
  );

  assign status_vec = found ? vec_of(int'(best_idx)) : '0;
  assign summary    = |pending;
  assign irq_req    = offer;
  assign irq_vec    = offer ? status_vec : '0;

  always_comb begin
    for (int k = 0; k < NUM_IRQ; k++) begin
      ack_hit_v[k]  = ack && offer && best_idx == IDX_W'(k);
      cmpl_hit_v[k] = cmpl && active[k] && cmpl_vec == vec_of(k);
    end
  end

  for (genvar k = 0; k < NUM_IRQ; k++) begin : g_line
    nvic_line #(.PRIO_BITS(PRIO_BITS)) u_line (
      .clk(clk), .rst_n(rst_n), .lvl(irq_lvl[k]),
      .en_set(en_set_v[k]), .en_clr(en_clr_v[k]),
      .pd_set(pd_set_v[k]), .pd_clr(pd_clr_v[k]),
      .prio_we(prio_we_v[k]), .prio_wd(prio_wd_v[k*PRIO_BITS +: PRIO_BITS]),
      .ack_hit(ack_hit_v[k]), .cmpl_hit(cmpl_hit_v[k]),
      .enable(enable[k]), .pending(pending[k]), .active(active[k]),
      .prio(prio_flat[k*PRIO_BITS +: PRIO_BITS]),
      .rise(rise_v[k]), .repend(repend_v[k]), .clr_block(clr_block_v[k])
    );
  end
endmodule

// File: rtl/nvic_ctrl_chk.sv
module nvic_ctrl_chk #(
  parameter int NUM_IRQ = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_lvl,
  input logic [NUM_IRQ-1:0] pending,
  input logic [NUM_IRQ-1:0] active,
  input logic [NUM_IRQ-1:0] rise_v,
  input logic [NUM_IRQ-1:0] cmpl_hit_v,
  input logic [NUM_IRQ-1:0] ack_hit_v,
  input logic [NUM_IRQ-1:0] clr_block_v,
  input logic [8:0]         status_vec,
  input logic               summary,
  input logic               irq_req,
  input logic [8:0]         irq_vec
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;

  AST_RISE_PENDS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    |rise_v |=> (pending & $past(rise_v)) == $past(rise_v)); // R1
  AST_REPEND_ON_CMPL: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    |(cmpl_hit_v & irq_lvl) |=> (pending & $past(cmpl_hit_v & irq_lvl)) == $past(cmpl_hit_v & irq_lvl)); // R2
  AST_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    |(clr_block_v & pending) |=> (pending & $past(clr_block_v & pending)) == $past(clr_block_v & pending)); // R3
  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_hit_v)); // R4
  AST_ACK_ACTIVATES: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    |ack_hit_v |=> (active & $past(ack_hit_v)) == $past(ack_hit_v)); // R4
  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    status_vec == 9'd0 || (status_vec >= 9'd16 && int'(status_vec) < NUM_IRQ + 16)); // R5
  AST_SUMMARY_COVERS_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    status_vec != 9'd0 |-> summary); // R6
  AST_REQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == status_vec && irq_vec != 9'd0)); // R8
endmodule

bind nvic_ctrl nvic_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .pending(pending), .active(active),
  .rise_v(rise_v), .cmpl_hit_v(cmpl_hit_v), .ack_hit_v(ack_hit_v),
  .clr_block_v(clr_block_v), .status_vec(status_vec), .summary(summary),
  .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/nvic_ctrl_bench.sv
module nvic_ctrl_bench;
  localparam int N  = 256;
  localparam int PB = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_lvl = '0;
  logic [9:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic         we = 1'b0;
  logic [31:0]  rdata;
  logic         irq_req;
  logic [8:0]   irq_vec;
  logic         ack = 1'b0;
  logic         cmpl = 1'b0;
  logic [8:0]   cmpl_vec = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  nvic_ctrl #(.NUM_IRQ(N), .PRIO_BITS(PB), .ADDR_W(10)) u_nvic_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_lvl(irq_lvl), .addr(addr), .wdata(wdata),
    .we(we), .rdata(rdata), .irq_req(irq_req), .irq_vec(irq_vec),
    .ack(ack), .cmpl(cmpl), .cmpl_vec(cmpl_vec)
  );

  // region codes from R10
  localparam logic [2:0] EN_SET = 3'd0, EN_CLR = 3'd1, PD_SET = 3'd2,
                         PD_CLR = 3'd3, ACT = 3'd4, PRIO = 3'd5, STAT = 3'd6;

  function automatic logic [31:0] status_word(bit any_pend, int vec);
    return (32'(any_pend) << 22) | (32'(vec) << 12);
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] rg, int idx, logic [31:0] d);
    @(negedge clk);
    addr = {rg, 7'(idx)}; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [2:0] rg, int idx, output logic [31:0] d);
    addr = {rg, 7'(idx)};
    #1 d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(STAT, 0, d);   check("R9 reset status", d, 32'h0);
    rd(EN_SET, 0, d); check("R9 reset enable", d, 32'h0);
    check("R9 reset irq_req", 32'(irq_req), 32'h0);
  endtask

  task automatic t_edge_and_clear_block();
    logic [31:0] d;
    @(negedge clk); irq_lvl[5] = 1'b1;
    @(negedge clk);
    rd(PD_SET, 0, d); check("R1 edge pends line 5", d, 32'h20);
    rd(STAT, 0, d);   check("R6 summary with disabled pending", d, status_word(1, 0));
    wr(PRIO, 1, 32'h0000_8000);
    wr(EN_SET, 0, 32'h20);
    rd(STAT, 0, d);   check("R5 vector of line 5", d, status_word(1, 21));
    check("R8 offer line 5", {22'd0, irq_req, irq_vec}, {22'd0, 1'b1, 9'd21});
    wr(PD_CLR, 0, 32'h20);
    rd(PD_CLR, 0, d); check("R3 clear ignored while high and idle", d, 32'h20);
  endtask

  task automatic t_ack_and_nest();
    logic [31:0] d;
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    rd(PD_SET, 0, d); check("R4 ack clears pending with line high", d, 32'h0);
    rd(ACT, 0, d);    check("R4 ack sets active", d, 32'h20);
    wr(PRIO, 1, 32'hA000_8000);
    @(negedge clk); irq_lvl[7] = 1'b1;
    wr(EN_SET, 0, 32'h80);
    check("R8 lower-urgency line blocked", 32'(irq_req), 32'h0);
    rd(STAT, 0, d);   check("R5 status still shows line 7", d, status_word(1, 23));
    wr(PRIO, 1, 32'h3F00_8000);
    rd(PRIO, 1, d);   check("R7 low priority bits read zero", d, 32'h2000_8000);
    check("R8 more urgent line nests", {22'd0, irq_req, irq_vec}, {22'd0, 1'b1, 9'd23});
    @(negedge clk); irq_lvl[7] = 1'b0;
    wr(PD_CLR, 0, 32'h80);
    rd(PD_SET, 0, d); check("R3 clear takes effect with line low", d, 32'h0);
  endtask

  task automatic t_repend();
    logic [31:0] d;
    @(negedge clk); cmpl = 1'b1; cmpl_vec = 9'd21;
    @(negedge clk); cmpl = 1'b0;
    rd(PD_SET, 0, d); check("R2 held line re-pends on completion", d, 32'h20);
    rd(ACT, 0, d);    check("R2 active cleared on completion", d, 32'h0);
    @(negedge clk); irq_lvl[5] = 1'b0;
    wr(PD_CLR, 0, 32'h20);
    wr(EN_CLR, 0, 32'hA0);
    rd(STAT, 0, d);   check("R3 cleared after line drops", d, 32'h0);
  endtask

  task automatic t_wide_vectors();
    logic [31:0] d;
    wr(PD_SET, 7, 32'h0401_0000);
    rd(STAT, 0, d);   check("R6 only disabled interrupts pending", d, status_word(1, 0));
    wr(EN_SET, 7, 32'h0401_0000);
    rd(STAT, 0, d);   check("R5 tie to lower number, vector 256", d, status_word(1, 256));
    wr(PRIO, 60, 32'h0000_0040);
    rd(STAT, 0, d);   check("R5 vector 266 in 9-bit field", d, status_word(1, 266));
    check("R8 offer vector 266", 32'(irq_vec), 32'd266);
    wr(EN_SET, 7, 32'h0);
    rd(EN_SET, 7, d); check("R9 zero write no effect", d, 32'h0401_0000);
    wr(EN_CLR, 7, 32'h0400_0000);
    rd(EN_CLR, 7, d); check("R10 clear-enable word 7", d, 32'h0001_0000);
    rd(STAT, 0, d);   check("R5 back to vector 256", d, status_word(1, 256));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge_and_clear_block();
    t_ack_and_nest();
    t_repend();
    t_wide_vectors();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule